// File: doc/BRIEF.md
# Multi-channel high-speed down-counting timer

This peripheral holds a parameterised number of independent 64-bit down-counters (two or four), all clocked from the bus clock, behind a plain APB-style register port. Each channel has its own 64-bit interval register, a control register and a live count that software can read. A channel runs in periodic mode, where it reloads its interval on every expiry, or in one-shot mode, where it stops after the first expiry. A 3-bit prescaler field slows counting by a power of two.

Each expiry sets the channel's pending flag in a shared status register. Software clears a flag by writing 1 to it. A shared enable register gates each pending flag onto that channel's own interrupt line. When software clears a channel's enable bit, the channel keeps counting for two more clock cycles before it stops, so a stop sequence must wait that long.

A channel loaded with an all-ones interval in periodic mode runs freely. The bit-inverted low count word then serves as a rising 32-bit time base.

Top module: `hst_timer`

## Requirements
- R1: After reset, every register reads 0 and every interrupt line is low.
- R2: Register map. Interrupt enable is at 0x00 and interrupt status at 0x04, with bit n belonging to channel n. Channel n has control at 0x10+0x20n, interval low and high words at 0x14+0x20n and 0x18+0x20n, and count low and high words at 0x1C+0x20n and 0x20+0x20n. Count reads return the live value. Unmapped addresses read 0.
- R3: Control bit 0 is enable, bit 1 is reload, bits 6:4 are the prescaler P, and bit 7 selects one-shot mode (1) or periodic mode (0). A write with reload set copies the interval into the count on the following cycle. The reload bit then reads back as 0. The load happens whether or not enable is set.
- R4: The count changes only on a load or on a tick. A tick comes every 2^P cycles while the channel is active. Each tick decrements a nonzero count. A tick that finds the count at 0 is an expiry. After a load of value L, the first expiry therefore lands (L+1)·2^P + 1 cycles after the control write.
- R5: Periodic mode: an expiry reloads the interval into the count, and the channel keeps running.
- R6: One-shot mode: an expiry clears the enable bit, the count stays at 0, and no further expiry follows.
- R7: An expiry sets the channel's status bit. Writing 1 to a status bit clears it. If an expiry and a clearing write fall in the same cycle, the set wins.
- R8: A channel's interrupt line is high exactly when both its status bit and its enable bit are 1.
- R9: When a control write clears enable on a running channel, the channel stays active for two more cycles and then stops. With P=0 the count therefore drops three times from the cycle of the write.
- R10: Writing the interval registers leaves the current count unchanged until the next reload.
- R11: With an all-ones interval in periodic mode, the bit-inverted count low word rises by one per cycle when P=0, and the count high word reads all ones.
- R12: Channels are independent: one channel's activity does not alter another channel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the counting source |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase; a write commits on the edge where psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW (12) | Byte address |
| pwdata | input | DW (32) | Write data |
| prdata | output | DW (32) | Read data, driven combinationally from paddr |
| irq | output | NUM_CH (2) | One interrupt line per channel |

## Verification
The bus port has no back-pressure: every access completes in its access phase, so the bench controls exactly which clock edge each write commits on. The two functions that can fall in the same cycle are a periodic expiry and a write-1-to-clear of the same status bit. The bench runs a channel with a 4-cycle period, clears the flag once, and times a second clear so that it commits on the edge of the next reload expiry. The pending line must stay high after that edge, and a later clear with no expiry in its cycle must bring the line low.

// File: rtl/hst_pkg.sv
package hst_pkg;
  // control field positions (software-visible encoding)
  localparam int unsigned CTL_EN_BIT  = 0;
  localparam int unsigned CTL_RLD_BIT = 1;
  localparam int unsigned CTL_PS_LSB  = 4;
  localparam int unsigned PS_W        = 3;
  localparam int unsigned CTL_OS_BIT  = 7;

  // address map
  localparam int unsigned OFF_IE     = 'h00;
  localparam int unsigned OFF_STS    = 'h04;
  localparam int unsigned CH_BASE    = 'h10;
  localparam int unsigned CH_STRIDE  = 'h20;
  localparam int unsigned SUB_CTL    = 'h00;
  localparam int unsigned SUB_IVL_LO = 'h04;
  localparam int unsigned SUB_IVL_HI = 'h08;
  localparam int unsigned SUB_CNT_LO = 'h0C;
  localparam int unsigned SUB_CNT_HI = 'h10;
endpackage

// File: rtl/hst_presc.sv
module hst_presc #(
  parameter int unsigned PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [PW-1:0] sel,
  output logic          tick
);
  localparam int unsigned DIVW = (1 << PW) - 1;

  logic [DIVW-1:0] div_q;
  logic [DIVW-1:0] mask;

  always_comb begin
    mask = '0;
    for (int k = 0; k < DIVW; k++) begin
      if (k < int'(sel)) mask[k] = 1'b1;
    end
  end

  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)   div_q <= '0;
    else if (clr) div_q <= '0;
    else if (run) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/hst_chan.sv
module hst_chan #(
  parameter int unsigned CW       = 64,
  parameter int unsigned PW       = 3,
  parameter int unsigned DIS_SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          w_en,
  input  logic          w_reload,
  input  logic [PW-1:0] w_presc,
  input  logic          w_oneshot,
  input  logic [CW-1:0] ivl,
  output logic          en,
  output logic          reload,
  output logic [PW-1:0] presc,
  output logic          oneshot,
  output logic [CW-1:0] cnt,
  output logic          active,
  output logic          tick,
  output logic          load,
  output logic          expire
);
  localparam int unsigned SW = $clog2(DIS_SYNC + 1);

  logic          en_q, reload_q, oneshot_q;
  logic [PW-1:0] presc_q;
  logic [SW-1:0] stop_q;
  logic [CW-1:0] cnt_q;
  logic          os_stop;

  assign active  = en_q || (stop_q != '0);
  assign load    = reload_q;
  assign expire  = tick && (cnt_q == '0);
  assign os_stop = expire && oneshot_q;

  hst_presc #(.PW(PW)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (active && !load),
    .clr  (load),
    .sel  (presc_q),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      reload_q  <= 1'b0;
      oneshot_q <= 1'b0;
      presc_q   <= '0;
      stop_q    <= '0;
      cnt_q     <= '0;
    end else begin
      if (load) reload_q <= 1'b0;
      if (stop_q != '0) stop_q <= stop_q - 1'b1;

      if (load) begin
        cnt_q <= ivl;
      end else if (tick) begin
        if (cnt_q == '0) begin
          if (!oneshot_q) cnt_q <= ivl;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      if (os_stop) begin
        en_q   <= 1'b0;
        stop_q <= '0;
      end

      if (ctl_we) begin
        en_q      <= w_en;
        reload_q  <= w_reload;
        presc_q   <= w_presc;
        oneshot_q <= w_oneshot;
        if (w_en) stop_q <= '0;
        else if (en_q && !os_stop) stop_q <= SW'(DIS_SYNC);
      end
    end
  end

  assign en      = en_q;
  assign reload  = reload_q;
  assign presc   = presc_q;
  assign oneshot = oneshot_q;
  assign cnt     = cnt_q;
endmodule

// File: rtl/hst_timer.sv
module hst_timer
  import hst_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned AW       = 12,
  parameter int unsigned DW       = 32,
  parameter int unsigned DIS_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int unsigned CW = 2 * DW;

  logic              wr;
  logic [NUM_CH-1:0] ie_q, sts_q, sts_clr;
  logic [NUM_CH-1:0] hit_ctl, hit_il, hit_ih, hit_cl, hit_ch;
  logic [NUM_CH-1:0] en_v, rld_v, os_v, act_v, tick_v, load_v, exp_v;
  logic [CW-1:0]     cnt_v [NUM_CH];
  logic [CW-1:0]     ivl_v [NUM_CH];
  logic [DW-1:0]     ctl_rd [NUM_CH];
  logic [DW-1:0]     rd;

  assign wr = psel && penable && pwrite;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int unsigned BASE = CH_BASE + CH_STRIDE * i;
    logic [CW-1:0] ivl_q;
    logic [PS_W-1:0] ps;

    assign hit_ctl[i] = (paddr == AW'(BASE + SUB_CTL));
    assign hit_il[i]  = (paddr == AW'(BASE + SUB_IVL_LO));
    assign hit_ih[i]  = (paddr == AW'(BASE + SUB_IVL_HI));
    assign hit_cl[i]  = (paddr == AW'(BASE + SUB_CNT_LO));
    assign hit_ch[i]  = (paddr == AW'(BASE + SUB_CNT_HI));

    always_ff @(posedge clk) begin
      if (!rst_n) ivl_q <= '0;
      else if (wr && hit_il[i]) ivl_q[DW-1:0]  <= pwdata;
      else if (wr && hit_ih[i]) ivl_q[CW-1:DW] <= pwdata;
    end
    assign ivl_v[i] = ivl_q;

    hst_chan #(.CW(CW), .PW(PS_W), .DIS_SYNC(DIS_SYNC)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (wr && hit_ctl[i]),
      .w_en     (pwdata[CTL_EN_BIT]),
      .w_reload (pwdata[CTL_RLD_BIT]),
      .w_presc  (pwdata[CTL_PS_LSB +: PS_W]),
      .w_oneshot(pwdata[CTL_OS_BIT]),
      .ivl      (ivl_q),
      .en       (en_v[i]),
      .reload   (rld_v[i]),
      .presc    (ps),
      .oneshot  (os_v[i]),
      .cnt      (cnt_v[i]),
      .active   (act_v[i]),
      .tick     (tick_v[i]),
      .load     (load_v[i]),
      .expire   (exp_v[i])
    );

    always_comb begin
      ctl_rd[i] = '0;
      ctl_rd[i][CTL_EN_BIT]              = en_v[i];
      ctl_rd[i][CTL_RLD_BIT]             = rld_v[i];
      ctl_rd[i][CTL_PS_LSB +: PS_W]      = ps;
      ctl_rd[i][CTL_OS_BIT]              = os_v[i];
    end
  end

  assign sts_clr = (wr && paddr == AW'(OFF_STS)) ? pwdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q  <= '0;
      sts_q <= '0;
    end else begin
      if (wr && paddr == AW'(OFF_IE)) ie_q <= pwdata[NUM_CH-1:0];
      sts_q <= (sts_q & ~sts_clr) | exp_v;
    end
  end

  assign irq = sts_q & ie_q;

  always_comb begin
    rd = '0;
    if (paddr == AW'(OFF_IE))  rd[NUM_CH-1:0] = ie_q;
    if (paddr == AW'(OFF_STS)) rd[NUM_CH-1:0] = sts_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit_ctl[i]) rd = ctl_rd[i];
      if (hit_il[i])  rd = ivl_v[i][DW-1:0];
      if (hit_ih[i])  rd = ivl_v[i][CW-1:DW];
      if (hit_cl[i])  rd = cnt_v[i][DW-1:0];
      if (hit_ch[i])  rd = cnt_v[i][CW-1:DW];
    end
  end

  assign prdata = rd;
endmodule

// File: rtl/hst_timer_chk.sv
module hst_timer_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CW     = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] ie_v,
  input logic [NUM_CH-1:0] sts_v,
  input logic [NUM_CH-1:0] en_v,
  input logic [NUM_CH-1:0] os_v,
  input logic [NUM_CH-1:0] act_v,
  input logic [NUM_CH-1:0] exp_v,
  input logic [NUM_CH-1:0] tick_v,
  input logic [NUM_CH-1:0] load_v,
  input logic [CW-1:0]     cnt_v [NUM_CH],
  input logic [CW-1:0]     ivl_v [NUM_CH]
);
  logic wr_any;
  assign wr_any = psel && penable && pwrite;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R7
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exp_v[i] |=> sts_v[i]);
    // R7
    sts_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_v[i]) |-> $past(exp_v[i]));
    // R5
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exp_v[i] && !os_v[i] |=> cnt_v[i] == $past(ivl_v[i]));
    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exp_v[i] && os_v[i] && !wr_any |=> !en_v[i] && cnt_v[i] == '0);
    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_v[i] && !load_v[i] |=> $stable(cnt_v[i]));
    // R9
    drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_v[i]) && !$past(exp_v[i]) |-> act_v[i]);
    // R9
    drain_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_v[i]) && !$past(exp_v[i]) |=> act_v[i]);
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> ie_v[i]);
  end
endmodule

bind hst_timer hst_timer_chk #(.NUM_CH(NUM_CH), .CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .psel   (psel),
  .penable(penable),
  .pwrite (pwrite),
  .irq    (irq),
  .ie_v   (ie_q),
  .sts_v  (sts_q),
  .en_v   (en_v),
  .os_v   (os_v),
  .act_v  (act_v),
  .exp_v  (exp_v),
  .tick_v (tick_v),
  .load_v (load_v),
  .cnt_v  (cnt_v),
  .ivl_v  (ivl_v)
);

// File: tb/tb_hst_timer.sv
module tb_hst_timer;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0]     paddr = '0;
  logic [DW-1:0]     pwdata = '0;
  logic [DW-1:0]     prdata;
  logic [NUM_CH-1:0] irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  hst_timer #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // called at a negedge; commits on the second following posedge; returns at the negedge after it
  task automatic apb_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(posedge clk);
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk); penable = 1'b1; #1 d = prdata;
    @(posedge clk);
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", 32'(irq), 32'h0);
    apb_rd('h00, v); chk("R1 ie", v, 0);
    apb_rd('h04, v); chk("R1 sts", v, 0);
    apb_rd('h10, v); chk("R1 ctl0", v, 0);
    apb_rd('h3C, v); chk("R1 cnt1", v, 0);
    apb_rd('h08, v); chk("R2 unmapped", v, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    apb_wr('h00, 32'h1);
    apb_wr('h14, 32'd3);
    apb_wr('h18, 32'd0);
    apb_wr('h10, 32'h03);                       // edge E
    chk("R8 irq low after start", 32'(irq[0]), 0);
    repeat (4) @(posedge clk); @(negedge clk);  // after E+4
    chk("R4 no expiry before period", 32'(irq[0]), 0);
    @(posedge clk); @(negedge clk);             // after E+5
    chk("R7 first expiry", 32'(irq[0]), 1);
    apb_wr('h04, 32'h1);                        // commit E+7
    chk("R7 w1c clears", 32'(irq[0]), 0);
    apb_wr('h04, 32'h1);                        // commit E+9 = expiry
    chk("R7 set wins over clear (R5 reload period)", 32'(irq[0]), 1);
    apb_wr('h04, 32'h1);                        // commit E+11
    chk("R7 clear without collision", 32'(irq[0]), 0);
    apb_wr('h10, 32'h00);                       // commit E+13, expiry also at E+13
    repeat (6) @(posedge clk); @(negedge clk);
    apb_rd('h1C, v); chk("R9 drain after periodic stop", v, 32'd1);
    apb_rd('h10, v); chk("R3 ctl cleared", v, 0);
    apb_wr('h04, 32'h1);
  endtask

  task automatic t_oneshot_presc();
    logic [31:0] v;
    apb_wr('h00, 32'h3);
    apb_wr('h34, 32'd1);
    apb_wr('h38, 32'd0);
    apb_wr('h30, 32'hA3);                       // one-shot, P=2, edge E
    repeat (8) @(posedge clk); @(negedge clk);
    chk("R4 prescaled no expiry yet", 32'(irq[1]), 0);
    @(posedge clk); @(negedge clk);
    chk("R4 prescaled expiry at (L+1)*4+1", 32'(irq[1]), 1);
    apb_rd('h30, v); chk("R6 enable cleared, fields kept", v, 32'hA0);
    apb_rd('h3C, v); chk("R6 count stays 0", v, 0);
    apb_wr('h04, 32'h2);
    repeat (40) @(posedge clk); @(negedge clk);
    chk("R6 no second expiry", 32'(irq[1]), 0);
  endtask

  task automatic t_reload_live();
    logic [31:0] v;
    apb_wr('h34, 32'd100);
    apb_wr('h30, 32'h03);                       // edge E
    apb_rd('h30, v); chk("R3 reload self-clears", v, 32'h01);
    apb_rd('h3C, v); chk("R2 live count low", v, 32'd98);
    apb_rd('h40, v); chk("R2 count high", v, 0);
    apb_wr('h30, 32'h00);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    apb_wr('h14, 32'd50);
    apb_wr('h10, 32'h03);                       // E
    apb_wr('h10, 32'h00);                       // E+2
    repeat (10) @(posedge clk); @(negedge clk);
    apb_rd('h1C, v); chk("R9 two extra counts after disable", v, 32'd47);
    apb_rd('h04, v); chk("R7 no spurious status", v, 0);
  endtask

  task automatic t_ivl_hold();
    logic [31:0] v;
    apb_wr('h14, 32'd9);
    apb_rd('h1C, v); chk("R10 interval write keeps count", v, 32'd47);
    apb_wr('h10, 32'h02);
    repeat (3) @(posedge clk); @(negedge clk);
    apb_rd('h1C, v); chk("R3 reload without enable", v, 32'd9);
    apb_rd('h10, v); chk("R3 ctl after reload-only", v, 0);
  endtask

  task automatic t_ie_mask();
    logic [31:0] v;
    apb_wr('h00, 32'h0);
    apb_wr('h34, 32'd0);
    apb_wr('h30, 32'h83);
    repeat (5) @(posedge clk); @(negedge clk);
    chk("R8 masked line low", 32'(irq[1]), 0);
    apb_rd('h04, v); chk("R7 status set while masked", v, 32'h2);
    apb_wr('h00, 32'h2);
    chk("R8 unmask raises line", 32'(irq[1]), 1);
    apb_wr('h04, 32'h2);
    chk("R8 clear drops line", 32'(irq[1]), 0);
  endtask

  task automatic t_freerun();
    logic [31:0] a, b, v;
    apb_wr('h34, 32'hFFFF_FFFF);
    apb_wr('h38, 32'hFFFF_FFFF);
    apb_wr('h30, 32'h03);
    repeat (5) @(posedge clk); @(negedge clk);
    apb_rd('h3C, a);
    apb_rd('h3C, b);
    chk("R11 inverted low word rises by 2", (~b) - (~a), 32'd2);
    apb_rd('h40, v); chk("R11 high word all ones", v, 32'hFFFF_FFFF);
    apb_rd('h1C, v); chk("R12 other channel untouched", v, 32'd9);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periodic();
    t_oneshot_presc();
    t_reload_live();
    t_disable();
    t_ivl_hold();
    t_ie_mask();
    t_freerun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule